// File: doc/BRIEF.md
# Power Port Overcurrent and Restart Timer

This block supervises four powered network ports. It sets how long each port may stay in overcurrent and when a port that was shut down may power up again. Every port has a gate-on request and two overcurrent flags from the analog front end. One flag reports current above the inrush limit. The other reports current above the steady-state limit. The block drives a gate enable and a latched fault indication for each port. All timing is counted in periods of a 1 kHz tick strobe. The block does not sense current itself.

When a port's gate turns on, a startup window begins. During that window the inrush flag is tolerated. If the inrush flag is still high on the tick that closes the window, the port is shut down as faulted. After startup the steady-state flag is timed: it must stay high for a full fault window of consecutive ticks to shut the port down. Any drop of the flag restarts the count. After a fault, an optional restart delay holds the port off. The delay is a power-of-two multiple of the fault window, or zero. One arbiter shared by all ports applies every turn-off, faulted or voluntary. It lets at most one port turn off per spacing interval and serves the lowest-numbered port first.

Top module: `poe_fault_timer`

## Requirements
- R1: A port that is idle turns its gate enable on at the first clock edge that samples its gate request high.
- R2: The inrush flag is ignored on the first WIN_TICKS-1 ticks after turn-on (WIN_TICKS=60 by default). If the flag is high on the WIN_TICKS-th tick, the port takes a faulted shutdown. Otherwise the port enters normal operation.
- R3: In normal operation, a steady-state flag that is high on WIN_TICKS consecutive ticks causes a faulted shutdown. A clock cycle with the flag low clears the count, so the next episode needs the full window again.
- R4: A port that must turn off keeps its gate on until the arbiter grants it. Grants happen only on tick cycles, and the first possible grant is the tick after the shutdown cause was registered. Dropping the gate request of a running port is also a turn-off that goes through the arbiter.
- R5: The block turns off at most one port per OFF_GAP_TICKS ticks (1 tick by default). Among waiting ports, the lowest index is served first.
- R6: If the restart enable is high when a faulted port is turned off, the restart code selects the wait before the port may turn on again. Code 2'b00 gives 16×WIN_TICKS ticks, 2'b01 gives 32×WIN_TICKS, 2'b10 gives 64×WIN_TICKS, and 2'b11 gives no wait.
- R7: If the restart enable is low when a faulted port is turned off, the port may turn on again at once, whatever the restart code.
- R8: During a restart wait the gate request has no effect. A request still held when the wait ends turns the port on at the next clock edge.
- R9: A port's fault output rises on the clock edge that turns the port off for a fault. It stays high until that port next turns on. A voluntary turn-off leaves it low.
- R10: While the active-low reset is low, every gate enable and fault output is low at once, with no turn-off spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 ms time strobe |
| restart_en_i | input | 1 | Enables the post-fault restart wait |
| restart_sel_i | input | 2 | Restart wait code (see R6) |
| gate_req_i | input | NUM_PORTS | Per-port gate-on request |
| su_oc_i | input | NUM_PORTS | Per-port inrush-limit overcurrent flag |
| flt_oc_i | input | NUM_PORTS | Per-port steady-state-limit overcurrent flag |
| gate_en_o | output | NUM_PORTS | Per-port gate enable |
| fault_o | output | NUM_PORTS | Per-port latched overcurrent fault |

## Verification
A loop over all four restart codes with the enable high, plus two codes with it low, drives one port through a full fault. For each row the bench measures the wait to the exact tick, which separates the three multipliers from each other and from the zero-wait cases. Inrush held across the window is compared with inrush dropped one tick early; this shows that only the closing tick matters. A steady-state episode broken by a single low cycle, followed by a second 59-tick episode, shows whether the count restarts or accumulates. Three ports released together show the one-per-tick spacing and the lowest-first order.

// File: rtl/poe_ft_pkg.sv
package poe_ft_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RUN,
    ST_OFFQ,
    ST_HOLD
  } port_state_e;

  localparam logic [1:0] RSEL_X16  = 2'b00;
  localparam logic [1:0] RSEL_X32  = 2'b01;
  localparam logic [1:0] RSEL_X64  = 2'b10;
  localparam logic [1:0] RSEL_NONE = 2'b11;
endpackage

// File: rtl/poe_port_ctrl.sv
module poe_port_ctrl
  import poe_ft_pkg::*;
#(
  parameter int WIN_TICKS = 60,
  parameter int CNT_W     = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       gate_req_i,
  input  logic       su_oc_i,
  input  logic       flt_oc_i,
  input  logic       restart_en_i,
  input  logic [1:0] restart_sel_i,
  input  logic       grant_i,
  output logic       off_req_o,
  output logic       gate_en_o,
  output logic       fault_o
);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_TICKS - 1);

  port_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_d;
  logic             flt_pend_q;
  logic             fault_q;

  always_comb begin
    unique case (restart_sel_i)
      RSEL_X16: lim_d = CNT_W'(WIN_TICKS * 16);
      RSEL_X32: lim_d = CNT_W'(WIN_TICKS * 32);
      RSEL_X64: lim_d = CNT_W'(WIN_TICKS * 64);
      default:  lim_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      lim_q      <= '0;
      flt_pend_q <= 1'b0;
      fault_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (gate_req_i) begin
          state_q <= ST_START;
          cnt_q   <= '0;
          fault_q <= 1'b0;
        end
        ST_START: begin
          if (!gate_req_i) begin
            state_q    <= ST_OFFQ;
            flt_pend_q <= 1'b0;
          end else if (tick_i) begin
            if (cnt_q == WIN_LAST) begin
              cnt_q <= '0;
              if (su_oc_i) begin
                state_q    <= ST_OFFQ;
                flt_pend_q <= 1'b1;
              end else begin
                state_q <= ST_RUN;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (!gate_req_i) begin
            state_q    <= ST_OFFQ;
            flt_pend_q <= 1'b0;
          end else if (!flt_oc_i) begin
            cnt_q <= '0;
          end else if (tick_i) begin
            if (cnt_q == WIN_LAST) begin
              state_q    <= ST_OFFQ;
              flt_pend_q <= 1'b1;
              cnt_q      <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_OFFQ: if (grant_i) begin
          cnt_q <= '0;
          if (flt_pend_q) begin
            fault_q <= 1'b1;
            if (restart_en_i && restart_sel_i != RSEL_NONE) begin
              state_q <= ST_HOLD;
              lim_q   <= lim_d;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_HOLD: if (tick_i) begin
          if (cnt_q == lim_q - 1'b1) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign off_req_o = (state_q == ST_OFFQ);
  assign gate_en_o = (state_q == ST_START) || (state_q == ST_RUN) || (state_q == ST_OFFQ);
  assign fault_o   = fault_q;
endmodule

// File: rtl/poe_off_arbiter.sv
module poe_off_arbiter #(
  parameter int NUM_PORTS     = 4,
  parameter int OFF_GAP_TICKS = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [NUM_PORTS-1:0] req_i,
  output logic [NUM_PORTS-1:0] grant_o
);
  localparam int GAP_W = (OFF_GAP_TICKS > 1) ? $clog2(OFF_GAP_TICKS + 1) : 1;
  localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(OFF_GAP_TICKS - 1);

  logic [GAP_W-1:0] gap_q;
  logic             open_win;

  assign open_win = tick_i && (gap_q == '0);

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (open_win && req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   gap_q <= '0;
    else if (|grant_o)             gap_q <= GAP_RELOAD;
    else if (tick_i && gap_q != 0) gap_q <= gap_q - 1'b1;
  end
endmodule

// File: rtl/poe_fault_timer.sv
module poe_fault_timer #(
  parameter int NUM_PORTS     = 4,
  parameter int WIN_TICKS     = 60,
  parameter int OFF_GAP_TICKS = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 restart_en_i,
  input  logic [1:0]           restart_sel_i,
  input  logic [NUM_PORTS-1:0] gate_req_i,
  input  logic [NUM_PORTS-1:0] su_oc_i,
  input  logic [NUM_PORTS-1:0] flt_oc_i,
  output logic [NUM_PORTS-1:0] gate_en_o,
  output logic [NUM_PORTS-1:0] fault_o
);
  localparam int CNT_W = $clog2(WIN_TICKS * 64 + 1);

  logic [NUM_PORTS-1:0] off_req;
  logic [NUM_PORTS-1:0] grant;

  poe_off_arbiter #(
    .NUM_PORTS    (NUM_PORTS),
    .OFF_GAP_TICKS(OFF_GAP_TICKS)
  ) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .req_i  (off_req),
    .grant_o(grant)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    poe_port_ctrl #(
      .WIN_TICKS(WIN_TICKS),
      .CNT_W    (CNT_W)
    ) u_port (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick_i),
      .gate_req_i   (gate_req_i[p]),
      .su_oc_i      (su_oc_i[p]),
      .flt_oc_i     (flt_oc_i[p]),
      .restart_en_i (restart_en_i),
      .restart_sel_i(restart_sel_i),
      .grant_i      (grant[p]),
      .off_req_o    (off_req[p]),
      .gate_en_o    (gate_en_o[p]),
      .fault_o      (fault_o[p])
    );
  end
endmodule

// File: rtl/poe_fault_timer_chk.sv
module poe_fault_timer_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic [NUM_PORTS-1:0] gate_en_o,
  input logic [NUM_PORTS-1:0] fault_o
);
  p_reset_all_off_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (gate_en_o == '0 && fault_o == '0));

  p_single_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones($past(gate_en_o) & ~gate_en_o) <= 1);

  p_off_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(gate_en_o) & ~gate_en_o)) |-> $past(tick_i));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    p_fault_with_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fault_o[i]) |-> $fell(gate_en_o[i]));
    p_fault_clear_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(fault_o[i]) |-> $rose(gate_en_o[i]));
  end
endmodule

bind poe_fault_timer poe_fault_timer_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .gate_en_o(gate_en_o),
  .fault_o  (fault_o)
);

// File: tb/sim_poe_fault_timer.sv
`timescale 1ns/1ps
module sim_poe_fault_timer;
  localparam int NP  = 4;
  localparam int WIN = 60;

  typedef struct packed {
    logic       en;
    logic [1:0] sel;
    int         wait_ticks;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{1'b1, 2'b00, 16 * WIN},
    '{1'b1, 2'b01, 32 * WIN},
    '{1'b1, 2'b10, 64 * WIN},
    '{1'b1, 2'b11, 0},
    '{1'b0, 2'b00, 0},
    '{1'b0, 2'b10, 0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          tick = 1'b0;
  logic          r_en = 1'b0;
  logic [1:0]    r_sel = 2'b00;
  logic [NP-1:0] req = '0;
  logic [NP-1:0] su_oc = '0;
  logic [NP-1:0] flt_oc = '0;
  logic [NP-1:0] gate_en;
  logic [NP-1:0] fault;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  poe_fault_timer #(.NUM_PORTS(NP), .WIN_TICKS(WIN), .OFF_GAP_TICKS(1)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_i       (tick),
    .restart_en_i (r_en),
    .restart_sel_i(r_sel),
    .gate_req_i   (req),
    .su_oc_i      (su_oc),
    .flt_oc_i     (flt_oc),
    .gate_en_o    (gate_en),
    .fault_o      (fault)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req = '0; su_oc = '0; flt_oc = '0; tick = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset gate", 32'(gate_en), 32'h0);
    check("R10 reset fault", 32'(fault), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // restart wait table on port 0
    for (int r = 0; r < 6; r++) begin
      do_reset();
      r_en = ROWS[r].en; r_sel = ROWS[r].sel;
      req[0] = 1'b1;
      @(negedge clk);
      check("R1 turn on", 32'(gate_en[0]), 32'h1);
      ticks(WIN);
      flt_oc[0] = 1'b1;
      ticks(WIN);
      check("R4 held until grant", 32'(gate_en[0]), 32'h1);
      req[0] = 1'b0; flt_oc[0] = 1'b0;
      ticks(1);
      check("R3 fault shutdown gate", 32'(gate_en[0]), 32'h0);
      check("R9 fault set", 32'(fault[0]), 32'h1);
      if (ROWS[r].wait_ticks > 0) begin
        ticks(ROWS[r].wait_ticks - 1);
        req[0] = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 request ignored in wait", 32'(gate_en[0]), 32'h0);
        ticks(1);
        check("R6 on at wait end", 32'(gate_en[0]), 32'h1);
        check("R9 fault cleared on turn-on", 32'(fault[0]), 32'h0);
      end else begin
        req[0] = 1'b1;
        @(negedge clk);
        check(ROWS[r].en ? "R6 zero wait code" : "R7 wait disabled", 32'(gate_en[0]), 32'h1);
        check("R9 fault cleared on turn-on", 32'(fault[0]), 32'h0);
      end
    end

    // inrush tolerated if dropped before the closing tick
    do_reset();
    r_en = 1'b0;
    req[1] = 1'b1; su_oc[1] = 1'b1;
    @(negedge clk);
    ticks(WIN - 1);
    check("R2 inrush tolerated", 32'(gate_en[1]), 32'h1);
    su_oc[1] = 1'b0;
    ticks(3);
    check("R2 startup passes", 32'(gate_en[1]), 32'h1);
    check("R2 no fault", 32'(fault[1]), 32'h0);

    // inrush on closing tick faults
    do_reset();
    req[1] = 1'b1; su_oc[1] = 1'b1;
    @(negedge clk);
    ticks(WIN);
    check("R4 inrush fault pending", 32'(gate_en[1]), 32'h1);
    req[1] = 1'b0;
    ticks(1);
    check("R2 inrush fault off", 32'(gate_en[1]), 32'h0);
    check("R2 inrush fault flag", 32'(fault[1]), 32'h1);

    // broken episode restarts the window
    do_reset();
    req[0] = 1'b1;
    @(negedge clk);
    ticks(WIN);
    flt_oc[0] = 1'b1;
    ticks(WIN - 1);
    flt_oc[0] = 1'b0;
    @(negedge clk);
    flt_oc[0] = 1'b1;
    ticks(WIN - 1);
    check("R3 episode count cleared", 32'(gate_en[0]), 32'h1);
    check("R3 no fault yet", 32'(fault[0]), 32'h0);
    ticks(1);
    req[0] = 1'b0; flt_oc[0] = 1'b0;
    ticks(1);
    check("R3 full episode faults", 32'(fault[0]), 32'h1);

    // reset with ports on and a fault latched
    req[3:1] = 3'b111;
    @(negedge clk);
    check("R1 multi turn on", 32'(gate_en), 32'hE);
    rst_n = 1'b0;
    #1;
    check("R10 async all off", 32'(gate_en), 32'h0);
    check("R10 fault cleared", 32'(fault), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    req = '0;
    @(negedge clk);

    // spacing and order of voluntary turn-offs
    do_reset();
    req = 4'b0111;
    @(negedge clk);
    ticks(2);
    req = '0;
    repeat (2) @(negedge clk);
    check("R4 still on before tick", 32'(gate_en), 32'h7);
    ticks(1);
    check("R5 lowest first", 32'(gate_en), 32'h6);
    ticks(1);
    check("R5 second off", 32'(gate_en), 32'h4);
    ticks(1);
    check("R5 third off", 32'(gate_en), 32'h0);
    check("R9 voluntary no fault", 32'(fault), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule